// File: doc/BRIEF.md
# Link Transaction Retry Sequencer

This block runs a single transaction on a serial slave link, from the moment the host asks for it until a final status is handed back. It tells a separate frame engine which frame to transmit, arms the receiver, and then chooses what to do next from the returned tag and the receiver's CRC verdict. The block itself generates every idle clock on the link: the initialisation run after reset, the mandatory run before each poll frame, the turnaround run before it either finishes or sends again, and the multi-phase break pattern. It does not build frames and does not compute CRCs.

There are three recovery paths, and the response decides which one is taken. If the slave answers busy, the block sends a data poll. If the response fails its CRC check, the block sends an error poll. If the slave reports that the command arrived corrupted, the block retransmits the whole host command. When a slave stays busy past its limit, the block sends it a terminate frame and reports an I/O error. When an external owner holds the link, the outputs are released and every request is refused.

Top module: `lrs_txn_seq`

## Requirements
- R1: After reset the block emits INIT_CLKS (16) idle ticks with `link_data` high. It raises no `ack` and no `fe_start` during that time, then waits for a request.
- R2: A response with a good CRC and tag 0 (ACK) ends the transaction with status 0 (OK). In that case `rd_data` holds the bytes that sit just above the 4 CRC bits of `rx_frame`, limited to the low `req_bytes` bytes, with the first byte received in the most significant position. Any other ending leaves `rd_data` unchanged.
- R3: A tag 1 (BUSY) with a good CRC gives exactly POLL_CLKS (21) idle ticks, followed by a send with `fe_sel` = 1 (data poll). At most BUSY_LIM (100) such polls are made.
- R4: The busy response that arrives after BUSY_LIM polls gives POLL_CLKS idle ticks and then a send with `fe_sel` = 3 (terminate). The transaction then ends with status 2 (I/O error), whatever the terminate frame returns.
- R5: A failed response CRC gives POLL_CLKS idle ticks and then a send with `fe_sel` = 2 (error poll), whatever the tag says. The failure that arrives after CRC_LIM (3) error polls ends the transaction with status 2.
- R6: A tag 2 with a good CRC ends the transaction with status 2 and makes no further send.
- R7: A tag 3 with a good CRC causes the host command (`fe_sel` = 0) to be sent again after the turnaround ticks, and the busy and CRC counts start over. The host command is transmitted at most CMD_LIM (3) times. A tag 3 on the last transmission ends the transaction with status 2.
- R8: A receiver timeout ends the transaction with status 3.
- R9: Every final response and every retransmission is preceded by exactly `cfg_send_dly` idle ticks with data high, counted from the last frame sent. A value of 0 gives no ticks at all.
- R10: A break request makes no send. It emits PRE_BRK_CLKS (16) ticks with data high, then BRK_CLKS (256) ticks with data low, then `cfg_echo_dly` plus POST_BRK_CLKS (16) ticks with data high, and finishes with status 0.
- R11: While `ext_mode` is high, `link_oe` is low, no ticks are emitted, and a request is acknowledged with status 1 (refused) without any send. When `ext_mode` falls, INIT_CLKS idle ticks are emitted.
- R12: `fe_start` stays high with `fe_sel` stable until `fe_done` arrives, `rx_arm` rises only after `fe_done`, and `ack` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transaction; only sampled while the block is idle |
| req_break | input | 1 | Request the break pattern in place of a command |
| req_bytes | input | SZ_W | Number of read bytes expected on ACK |
| ack | output | 1 | One-cycle completion pulse |
| status | output | 2 | Final status: 0 OK, 1 refused, 2 I/O error, 3 timeout |
| rd_data | output | DATA_BYTES*8 | Read data captured on ACK |
| ext_mode | input | 1 | An external owner holds the link |
| cfg_send_dly | input | DLY_W | Turnaround idle tick count |
| cfg_echo_dly | input | DLY_W | Echo idle tick count used inside the break pattern |
| fe_start | output | 1 | Frame engine transmit request, held until done |
| fe_sel | output | 2 | Frame select: 0 host command, 1 data poll, 2 error poll, 3 terminate |
| fe_done | input | 1 | Frame and echo delay finished |
| rx_arm | output | 1 | Receiver armed to collect a response |
| rx_valid | input | 1 | Response collected |
| rx_tag | input | 2 | Response tag |
| rx_crc_ok | input | 1 | Response CRC good |
| rx_timeout | input | 1 | No start bit seen in time |
| rx_frame | input | DATA_BYTES*8+4 | Right-aligned response bits, with the 4 CRC bits lowest |
| link_tick | output | 1 | One idle link clock in this cycle |
| link_data | output | 1 | Data level for idle ticks |
| link_oe | output | 1 | Link drivers enabled |

## Verification
The assertions rely on three things from the neighbours. The frame engine answers `fe_start` with a single `fe_done` pulse. The receiver gives one `rx_valid` pulse for each time `rx_arm` is raised. `ext_mode` changes only while the block is idle. The bench models both neighbours with a responder that waits for `fe_start` and then for `rx_arm` before it answers, and it plays back responses from a script. It changes `ext_mode` only between transactions.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    typedef enum logic [2:0] {S_CLK, S_IDLE, S_SEND, S_RESP, S_DONE} state_e;
    typedef enum logic [2:0] {A_IDLE, A_SEND, A_DONE, A_LOW, A_ECHO, A_POST} after_e;
    typedef enum logic [1:0] {SEL_HOST = 2'd0, SEL_DPOLL = 2'd1, SEL_EPOLL = 2'd2, SEL_TERM = 2'd3} sel_e;
    typedef enum logic [1:0] {STS_OK = 2'd0, STS_REFUSED = 2'd1, STS_IOERR = 2'd2, STS_TIMEOUT = 2'd3} sts_e;
    typedef enum logic [2:0] {C_ACK, C_BUSY, C_ERRA, C_ERRC, C_CRC, C_TMO} cls_e;

    localparam logic [1:0] TAG_ACK  = 2'd0;
    localparam logic [1:0] TAG_BUSY = 2'd1;
    localparam logic [1:0] TAG_ERRA = 2'd2;
endpackage

// File: rtl/lrs_resp_class.sv
module lrs_resp_class
    import lrs_pkg::*;
(
    input  logic [1:0] tag,
    input  logic       crc_ok,
    input  logic       timeout,
    output cls_e       cls
);
    // Timeout wins, then CRC, then the tag.
    always_comb begin
        if (timeout)              cls = C_TMO;
        else if (!crc_ok)         cls = C_CRC;
        else if (tag == TAG_ACK)  cls = C_ACK;
        else if (tag == TAG_BUSY) cls = C_BUSY;
        else if (tag == TAG_ERRA) cls = C_ERRA;
        else                      cls = C_ERRC;
    end
endmodule

// File: rtl/lrs_byte_pick.sv
module lrs_byte_pick #(
    parameter int DATA_BYTES = 4,
    localparam int SZ_W    = $clog2(DATA_BYTES + 1),
    localparam int FRAME_W = DATA_BYTES * 8 + 4
) (
    input  logic [FRAME_W-1:0]      frame,
    input  logic [SZ_W-1:0]         nbytes,
    output logic [DATA_BYTES*8-1:0] data
);
    logic unused_crc_bits;
    assign unused_crc_bits = ^frame[3:0];

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        assign data[8*i +: 8] = (i < int'(nbytes)) ? frame[4 + 8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/lrs_txn_seq.sv
module lrs_txn_seq
    import lrs_pkg::*;
#(
    parameter int DATA_BYTES    = 4,
    parameter int BUSY_LIM      = 100,
    parameter int CRC_LIM       = 3,
    parameter int CMD_LIM       = 3,
    parameter int INIT_CLKS     = 16,
    parameter int POLL_CLKS     = 21,
    parameter int PRE_BRK_CLKS  = 16,
    parameter int BRK_CLKS      = 256,
    parameter int POST_BRK_CLKS = 16,
    parameter int DLY_W         = 8,
    localparam int SZ_W    = $clog2(DATA_BYTES + 1),
    localparam int DATA_W  = DATA_BYTES * 8,
    localparam int FRAME_W = DATA_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_break,
    input  logic [SZ_W-1:0]    req_bytes,
    output logic               ack,
    output logic [1:0]         status,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               ext_mode,
    input  logic [DLY_W-1:0]   cfg_send_dly,
    input  logic [DLY_W-1:0]   cfg_echo_dly,
    output logic               fe_start,
    output logic [1:0]         fe_sel,
    input  logic               fe_done,
    output logic               rx_arm,
    input  logic               rx_valid,
    input  logic [1:0]         rx_tag,
    input  logic               rx_crc_ok,
    input  logic               rx_timeout,
    input  logic [FRAME_W-1:0] rx_frame,
    output logic               link_tick,
    output logic               link_data,
    output logic               link_oe
);
    localparam int M1     = (BRK_CLKS > PRE_BRK_CLKS) ? BRK_CLKS : PRE_BRK_CLKS;
    localparam int M2     = (M1 > POST_BRK_CLKS) ? M1 : POST_BRK_CLKS;
    localparam int M3     = (M2 > INIT_CLKS) ? M2 : INIT_CLKS;
    localparam int M4     = (M3 > POLL_CLKS) ? M3 : POLL_CLKS;
    localparam int MAXC   = (M4 > (2**DLY_W - 1)) ? M4 : (2**DLY_W - 1);
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int BUSY_W = $clog2(BUSY_LIM + 1);
    localparam int CRC_W  = $clog2(CRC_LIM + 1);
    localparam int CMD_W  = $clog2(CMD_LIM + 1);

    typedef struct packed {
        state_e             st;
        after_e             aft;
        logic [CNT_W-1:0]   cnt;
        logic               dat;
        sel_e               sel;
        logic               abort;
        logic [BUSY_W-1:0]  nbusy;
        logic [CRC_W-1:0]   ncrc;
        logic [CMD_W-1:0]   ncmd;
        sts_e               sts;
        logic [SZ_W-1:0]    nby;
        logic [DATA_W-1:0]  rdat;
        logic               ext_prev;
    } seq_t;

    seq_t q, d;
    cls_e cls;
    logic [DATA_W-1:0] picked;

    lrs_resp_class u_class (
        .tag     (rx_tag),
        .crc_ok  (rx_crc_ok),
        .timeout (rx_timeout),
        .cls     (cls)
    );

    lrs_byte_pick #(.DATA_BYTES(DATA_BYTES)) u_pick (
        .frame  (rx_frame),
        .nbytes (q.nby),
        .data   (picked)
    );

    always_comb begin
        d = q;
        d.ext_prev = ext_mode;
        case (q.st)
            S_CLK: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    case (q.aft)
                        A_IDLE: d.st = S_IDLE;
                        A_SEND: d.st = S_SEND;
                        A_DONE: d.st = S_DONE;
                        A_LOW: begin
                            d.cnt = CNT_W'(BRK_CLKS);
                            d.dat = 1'b0;
                            d.aft = A_ECHO;
                        end
                        A_ECHO: begin
                            d.cnt = CNT_W'(cfg_echo_dly);
                            d.dat = 1'b1;
                            d.aft = A_POST;
                        end
                        A_POST: begin
                            d.cnt = CNT_W'(POST_BRK_CLKS);
                            d.aft = A_DONE;
                        end
                        default: d.st = S_IDLE;
                    endcase
                end
            end
            S_IDLE: begin
                if (q.ext_prev && !ext_mode) begin
                    d.st  = S_CLK;
                    d.cnt = CNT_W'(INIT_CLKS);
                    d.dat = 1'b1;
                    d.aft = A_IDLE;
                end else if (req) begin
                    if (ext_mode) begin
                        d.sts = STS_REFUSED;
                        d.st  = S_DONE;
                    end else if (req_break) begin
                        d.sts = STS_OK;
                        d.st  = S_CLK;
                        d.cnt = CNT_W'(PRE_BRK_CLKS);
                        d.dat = 1'b1;
                        d.aft = A_LOW;
                    end else begin
                        d.nby   = req_bytes;
                        d.sel   = SEL_HOST;
                        d.abort = 1'b0;
                        d.nbusy = '0;
                        d.ncrc  = '0;
                        d.ncmd  = '0;
                        d.st    = S_SEND;
                    end
                end
            end
            S_SEND: begin
                if (fe_done) d.st = S_RESP;
            end
            S_RESP: begin
                if (rx_valid) begin
                    // Common defaults: a turnaround run, then completion.
                    d.st  = S_CLK;
                    d.dat = 1'b1;
                    d.cnt = CNT_W'(cfg_send_dly);
                    d.aft = A_DONE;
                    if (q.abort) begin
                        d.sts = STS_IOERR;
                    end else begin
                        case (cls)
                            C_TMO: d.sts = STS_TIMEOUT;
                            C_ACK: begin
                                d.sts  = STS_OK;
                                d.rdat = picked;
                            end
                            C_ERRA: d.sts = STS_IOERR;
                            C_CRC: begin
                                if (int'(q.ncrc) < CRC_LIM) begin
                                    d.ncrc = q.ncrc + 1'b1;
                                    d.cnt  = CNT_W'(POLL_CLKS);
                                    d.aft  = A_SEND;
                                    d.sel  = SEL_EPOLL;
                                end else begin
                                    d.sts = STS_IOERR;
                                end
                            end
                            C_BUSY: begin
                                d.cnt = CNT_W'(POLL_CLKS);
                                d.aft = A_SEND;
                                if (int'(q.nbusy) < BUSY_LIM) begin
                                    d.nbusy = q.nbusy + 1'b1;
                                    d.sel   = SEL_DPOLL;
                                end else begin
                                    d.sel   = SEL_TERM;
                                    d.abort = 1'b1;
                                end
                            end
                            default: begin // command CRC error at the slave
                                if (int'(q.ncmd) + 1 < CMD_LIM) begin
                                    d.ncmd  = q.ncmd + 1'b1;
                                    d.nbusy = '0;
                                    d.ncrc  = '0;
                                    d.sel   = SEL_HOST;
                                    d.aft   = A_SEND;
                                end else begin
                                    d.sts = STS_IOERR;
                                end
                            end
                        endcase
                    end
                end
            end
            S_DONE: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= S_CLK;
            q.aft      <= A_IDLE;
            q.cnt      <= CNT_W'(INIT_CLKS);
            q.dat      <= 1'b1;
            q.sel      <= SEL_HOST;
            q.sts      <= STS_OK;
        end else begin
            q <= d;
        end
    end

    assign ack       = (q.st == S_DONE);
    assign status    = q.sts;
    assign rd_data   = q.rdat;
    assign fe_start  = (q.st == S_SEND);
    assign fe_sel    = q.sel;
    assign rx_arm    = (q.st == S_RESP);
    assign link_tick = (q.st == S_CLK) && (q.cnt != '0) && !ext_mode;
    assign link_data = (q.st == S_CLK) ? q.dat : 1'b1;
    assign link_oe   = !ext_mode;
endmodule

// File: rtl/lrs_txn_seq_chk.sv
module lrs_txn_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [1:0]        status,
    input logic [DATA_W-1:0] rd_data,
    input logic              ext_mode,
    input logic              fe_start,
    input logic [1:0]        fe_sel,
    input logic              fe_done,
    input logic              rx_arm,
    input logic              rx_valid
);
    p_ack_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_start_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_start && !fe_done) |=> (fe_start && $stable(fe_sel)));

    p_arm_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_arm) |-> $past(fe_done));

    p_refuse_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && status == 2'd1) |-> $past(ext_mode));

    p_no_send_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && $past(ext_mode) && !$past(fe_start)) |-> !fe_start);

    p_rdata_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $past(rx_valid && rx_arm));
endmodule

bind lrs_txn_seq lrs_txn_seq_chk #(.DATA_W(DATA_BYTES * 8)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .status   (status),
    .rd_data  (rd_data),
    .ext_mode (ext_mode),
    .fe_start (fe_start),
    .fe_sel   (fe_sel),
    .fe_done  (fe_done),
    .rx_arm   (rx_arm),
    .rx_valid (rx_valid)
);

// File: tb/tb_lrs_txn_seq.sv
module tb_lrs_txn_seq;
    localparam int SEND_DLY = 6;
    localparam int ECHO_DLY = 5;

    logic        clk, rst_n, req, req_break, ack, ext_mode;
    logic [2:0]  req_bytes;
    logic [1:0]  status, fe_sel, rx_tag;
    logic [31:0] rd_data;
    logic [7:0]  cfg_send_dly, cfg_echo_dly;
    logic        fe_start, fe_done, rx_arm, rx_valid, rx_crc_ok, rx_timeout;
    logic [35:0] rx_frame;
    logic        link_tick, link_data, link_oe;

    lrs_txn_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_break(req_break), .req_bytes(req_bytes),
        .ack(ack), .status(status), .rd_data(rd_data), .ext_mode(ext_mode),
        .cfg_send_dly(cfg_send_dly), .cfg_echo_dly(cfg_echo_dly),
        .fe_start(fe_start), .fe_sel(fe_sel), .fe_done(fe_done),
        .rx_arm(rx_arm), .rx_valid(rx_valid), .rx_tag(rx_tag), .rx_crc_ok(rx_crc_ok),
        .rx_timeout(rx_timeout), .rx_frame(rx_frame),
        .link_tick(link_tick), .link_data(link_data), .link_oe(link_oe)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string name, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", name, act, exp);
        end
    endtask

    // Response script, played back by the responder
    logic [1:0]  sc_tag [0:127];
    logic        sc_crc [0:127];
    logic        sc_tmo [0:127];
    logic [35:0] sc_frm [0:127];

    task automatic set_resp(input int i, input logic [1:0] t, input logic c,
                            input logic tmo, input logic [35:0] f);
        sc_tag[i] = t; sc_crc[i] = c; sc_tmo[i] = tmo; sc_frm[i] = f;
    endtask

    // Frame engine and receiver model
    int ridx;
    initial begin
        fe_done = 0; rx_valid = 0; rx_tag = 0; rx_crc_ok = 1; rx_timeout = 0; rx_frame = 0;
        ridx = 0;
        forever begin
            @(negedge clk);
            if (ack) ridx = 0;
            if (fe_start) begin
                @(negedge clk);
                @(negedge clk);
                fe_done = 1;
                @(negedge clk);
                fe_done = 0;
            end else if (rx_arm) begin
                rx_tag = sc_tag[ridx]; rx_crc_ok = sc_crc[ridx];
                rx_timeout = sc_tmo[ridx]; rx_frame = sc_frm[ridx];
                rx_valid = 1;
                if (ridx < 127) ridx++;
                @(negedge clk);
                rx_valid = 0;
            end
        end
    end

    // Monitor: link ticks, sends and completion snapshots
    int tot_ticks = 0, ticks = 0, nsends = 0, nacks = 0, hi_b = 0, lo = 0, hi_a = 0;
    int a_ticks, a_nsends, a_hi_b, a_lo, a_hi_a;
    int sel_log [0:127];
    int tick_log [0:127];
    logic [1:0]  a_sts;
    logic [31:0] a_rd;
    logic clr = 0;
    logic fs_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (clr) begin
                ticks = 0; nsends = 0; hi_b = 0; lo = 0; hi_a = 0; clr = 0;
            end
            if (link_tick) begin
                tot_ticks++; ticks++;
                if (!link_data) lo++;
                else if (lo == 0) hi_b++;
                else hi_a++;
            end
            if (fe_start && !fs_prev) begin
                if (nsends < 128) begin
                    sel_log[nsends] = int'(fe_sel);
                    tick_log[nsends] = ticks;
                end
                nsends++;
                ticks = 0;
            end
            fs_prev = fe_start;
            if (ack) begin
                a_sts = status; a_rd = rd_data; a_ticks = ticks; a_nsends = nsends;
                a_hi_b = hi_b; a_lo = lo; a_hi_a = hi_a;
                nacks++; clr = 1;
            end
        end
    end

    task automatic do_txn(input logic brk, input int nb);
        int n0;
        int k;
        n0 = nacks;
        @(negedge clk);
        req = 1; req_break = brk; req_bytes = 3'(nb);
        @(negedge clk);
        req = 0; req_break = 0;
        k = 0;
        while (nacks == n0 && k < 20000) begin
            @(negedge clk);
            k++;
        end
        if (nacks == n0) begin
            n_err++;
            $display("FAIL R12: no ack, actual %0d expected %0d", nacks, n0 + 1);
        end
    endtask

    typedef struct packed {
        logic [1:0]  tag;
        logic        crc;
        logic        tmo;
        logic [2:0]  nb;
        logic [35:0] frm;
        logic [1:0]  sts;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd0, 1'b1, 1'b0, 3'd4, 36'h123456789, 2'd0, 32'h12345678},
        '{2'd0, 1'b1, 1'b0, 3'd2, 36'hABCDEF012, 2'd0, 32'h0000EF01},
        '{2'd0, 1'b1, 1'b0, 3'd1, 36'h000000C35, 2'd0, 32'h000000C3},
        '{2'd2, 1'b1, 1'b0, 3'd4, 36'h0,         2'd2, 32'h000000C3},
        '{2'd0, 1'b1, 1'b1, 3'd4, 36'h0,         2'd3, 32'h000000C3},
        '{2'd0, 1'b1, 1'b0, 3'd0, 36'hFFFFFFFFF, 2'd0, 32'h00000000}
    };

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 0; req = 0; req_break = 0; req_bytes = 0; ext_mode = 0;
        cfg_send_dly = 8'(SEND_DLY); cfg_echo_dly = 8'(ECHO_DLY);
        for (int i = 0; i < 128; i++) set_resp(i, 2'd0, 1'b1, 1'b0, 36'h0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (30) @(negedge clk);
        // R1: reset state and initialisation run
        chk("R1 init ticks", tot_ticks, 16);
        chk("R1 no ack", nacks, 0);
        chk("R1 no send", nsends, 0);
        chk("R1 data high", link_data, 1);

        // R2 R6 R8 R9: single-response table
        for (int v = 0; v < 6; v++) begin
            set_resp(0, VEC[v].tag, VEC[v].crc, VEC[v].tmo, VEC[v].frm);
            do_txn(1'b0, int'(VEC[v].nb));
            chk($sformatf("R2/R6/R8 status row %0d", v), a_sts, VEC[v].sts);
            chk($sformatf("R2 rd_data row %0d", v), a_rd, VEC[v].rd);
            chk($sformatf("R6 sends row %0d", v), a_nsends, 1);
            chk($sformatf("R9 turnaround row %0d", v), a_ticks, SEND_DLY);
            if (v == 0) begin
                @(negedge clk);
                chk("R12 ack single cycle", ack, 0);
            end
        end

        // R3: busy, busy, ack
        set_resp(0, 2'd1, 1, 0, 36'h0);
        set_resp(1, 2'd1, 1, 0, 36'h0);
        set_resp(2, 2'd0, 1, 0, 36'h0AA55AA55);
        do_txn(1'b0, 4);
        chk("R3 sends", a_nsends, 3);
        chk("R3 poll sel", sel_log[1], 1);
        chk("R3 poll ticks", tick_log[1], 21);
        chk("R3 second poll ticks", tick_log[2], 21);
        chk("R3 status", a_sts, 0);
        chk("R2 data after polls", a_rd, 32'h0AA55AA5);

        // R4: busy limit leads to terminate
        for (int i = 0; i < 101; i++) set_resp(i, 2'd1, 1, 0, 36'h0);
        set_resp(101, 2'd0, 1, 0, 36'h0);
        do_txn(1'b0, 4);
        chk("R4 sends", a_nsends, 102);
        chk("R4 last poll sel", sel_log[100], 1);
        chk("R4 term sel", sel_log[101], 3);
        chk("R4 term ticks", tick_log[101], 21);
        chk("R4 status", a_sts, 2);

        // R5: CRC failure (tag says ERRA) then ack
        set_resp(0, 2'd2, 0, 0, 36'h0);
        set_resp(1, 2'd0, 1, 0, 36'h0);
        do_txn(1'b0, 4);
        chk("R5 sends", a_nsends, 2);
        chk("R5 epoll sel", sel_log[1], 2);
        chk("R5 epoll ticks", tick_log[1], 21);
        chk("R5 status recovered", a_sts, 0);

        // R5: CRC limit
        for (int i = 0; i < 4; i++) set_resp(i, 2'd0, 0, 0, 36'h0);
        do_txn(1'b0, 4);
        chk("R5 limit sends", a_nsends, 4);
        chk("R5 limit status", a_sts, 2);

        // R7: ERRC then ack
        set_resp(0, 2'd3, 1, 0, 36'h0);
        set_resp(1, 2'd0, 1, 0, 36'h0);
        do_txn(1'b0, 4);
        chk("R7 sends", a_nsends, 2);
        chk("R7 resend sel", sel_log[1], 0);
        chk("R9 resend ticks", tick_log[1], SEND_DLY);
        chk("R7 status", a_sts, 0);

        // R7: ERRC limit
        for (int i = 0; i < 3; i++) set_resp(i, 2'd3, 1, 0, 36'h0);
        do_txn(1'b0, 4);
        chk("R7 limit sends", a_nsends, 3);
        chk("R7 limit status", a_sts, 2);

        // R7: counts start over after a retransmission
        for (int i = 0; i < 3; i++) set_resp(i, 2'd0, 0, 0, 36'h0);
        set_resp(3, 2'd3, 1, 0, 36'h0);
        for (int i = 4; i < 7; i++) set_resp(i, 2'd0, 0, 0, 36'h0);
        set_resp(7, 2'd0, 1, 0, 36'h0);
        do_txn(1'b0, 4);
        chk("R7 reset counts sends", a_nsends, 8);
        chk("R7 reset counts status", a_sts, 0);

        // R9: zero turnaround
        cfg_send_dly = 8'd0;
        set_resp(0, 2'd0, 1, 0, 36'h0);
        do_txn(1'b0, 4);
        chk("R9 zero delay", a_ticks, 0);
        cfg_send_dly = 8'(SEND_DLY);

        // R10: break pattern
        do_txn(1'b1, 0);
        chk("R10 pre high", a_hi_b, 16);
        chk("R10 low", a_lo, 256);
        chk("R10 post high", a_hi_a, ECHO_DLY + 16);
        chk("R10 no send", a_nsends, 0);
        chk("R10 status", a_sts, 0);

        // R11: external mode
        begin
            int t0;
            @(negedge clk);
            ext_mode = 1;
            repeat (2) @(negedge clk);
            chk("R11 oe released", link_oe, 0);
            t0 = tot_ticks;
            do_txn(1'b0, 4);
            chk("R11 refused", a_sts, 1);
            chk("R11 no send", a_nsends, 0);
            chk("R11 no ticks", tot_ticks, t0);
            @(negedge clk);
            ext_mode = 0;
            repeat (40) @(negedge clk);
            chk("R11 reinit ticks", tot_ticks, t0 + 16);
            chk("R11 oe back", link_oe, 1);
        end
        set_resp(0, 2'd0, 1, 0, 36'h0);
        do_txn(1'b0, 4);
        chk("R11 served after release", a_sts, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule